// File: doc/BRIEF.md
# Packed Bit-Field Array Reader

This block reads one element from an array of equal-width fields that are packed back to back, with no padding, in a memory of 32-bit words. The caller gives an element index and a field width from 1 to 31 bits, then pulses `start`. The block multiplies the index by the width to find the element's first bit. It reads the word that holds that bit and the word after it through a synchronous read port with one cycle of latency. It joins the two words into a 64-bit window, shifts the window right by the bit offset inside the first word, and keeps only the low `width` bits.

A field of any width can cross a word boundary, odd widths such as 3, 5, 7 or 17 included. The two-word window always holds the whole field. Both words are read on every request, so a valid request always finishes in the same number of cycles. A width that is out of range is rejected at once. The block raises an error flag and returns zero without touching memory.

Top module: `packed_field_reader`

## Requirements
- R1: An accepted request with a valid width computes the bit position P = index × width. It issues exactly two memory reads on consecutive cycles: the first at word address P >> 5 and the second at (P >> 5) + 1.
- R2: The window is formed with the first word as bits 31..0 and the second word as bits 63..32. `result` equals the window shifted right by P[4:0] and masked to the low `width` bits. Bits of `result` at positions `width` and above are zero.
- R3: A field whose bits span two memory words, at any width from 1 to 31, is returned correctly.
- R4: For a valid width, `done` is high in the 4th cycle after the clock edge that accepts `start`. The reads happen in the 1st and 2nd of those cycles, even when the field lies entirely inside one word.
- R5: A width of 0, or of 32 to 63, sets `err` to 1 and `result` to 0, and issues no memory read. `done` is high in the 1st cycle after acceptance.
- R6: `done` is high for exactly one cycle per request. `result` and `err` keep their values from that point until the next accepted `start`. A valid request clears `err`.
- R7: `busy` is high from acceptance through the `done` cycle. A `start` seen while `busy` is high is ignored and does not change the request in progress.
- R8: After reset, `busy`, `done`, `err` and `mem_req` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| index | input | IDX_W | Element index |
| width | input | WID_W | Field width in bits, valid range 1..31 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had an invalid width |
| result | output | 32 | Extracted field, zero-extended |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_req` |

## Verification
The hardest situation to produce from the ports is a second `start` arriving while a request is still in flight. Its different index and width must be dropped, and the captured operands must survive. The bench raises `start` again in the middle of a read with an invalid width. It then confirms that the addresses, the latency and the result all belong to the first request. Boundary-crossing fields come from indices chosen so that P[4:0] + width exceeds 32 for widths 3, 7, 17 and 31. The bench compares each result against a reference built one bit at a time from its own copy of memory.

// File: rtl/packed_field_reader.sv
module packed_field_reader #(
  parameter int IDX_W  = 16,
  parameter int WID_W  = 6,
  parameter int ADDR_W = IDX_W + WID_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  index,
  input  logic [WID_W-1:0]  width,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       result,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata
);
  localparam int POS_W = IDX_W + WID_W;

  typedef enum logic [2:0] {S_IDLE, S_READ0, S_READ1, S_ALIGN, S_DONE} st_t;
  st_t state;

  logic [POS_W-1:0]  pos_q;
  logic [4:0]        wid_q;
  logic [31:0]       lo_q;
  logic [ADDR_W-1:0] base;
  logic [63:0]       win;
  logic [31:0]       mask;
  logic [31:0]       aligned;

  wire take = start && (state == S_IDLE);
  wire bad  = (width == '0) || (width > WID_W'(31));

  assign base     = ADDR_W'(pos_q >> 5);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);
  assign mem_req  = (state == S_READ0) || (state == S_READ1);
  assign mem_addr = (state == S_READ1) ? base + ADDR_W'(1) : base;
  assign win      = {mem_rdata, lo_q} >> pos_q[4:0];
  assign mask     = (32'h1 << wid_q) - 32'h1;
  assign aligned  = win[31:0] & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pos_q  <= '0;
      wid_q  <= '0;
      lo_q   <= '0;
      err    <= 1'b0;
      result <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          pos_q <= POS_W'(index) * POS_W'(width);
          wid_q <= width[4:0];
          err   <= bad;
          if (bad) begin
            result <= '0;
            state  <= S_DONE;
          end else begin
            state  <= S_READ0;
          end
        end
        S_READ0: state <= S_READ1;
        S_READ1: begin
          lo_q  <= mem_rdata;
          state <= S_ALIGN;
        end
        S_ALIGN: begin
          result <= aligned;
          state  <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == 32'h0));
  p_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((result >> wid_q) == 32'h0));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(result) && $stable(err)));
endmodule

// File: tb/packed_field_reader_tb.sv
module packed_field_reader_tb_top;
  localparam int IDX_W  = 16;
  localparam int WID_W  = 6;
  localparam int ADDR_W = IDX_W + WID_W - 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [IDX_W-1:0]  index = '0;
  logic [WID_W-1:0]  width = '0;
  logic              busy, done, err, mem_req;
  logic [31:0]       result;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_rdata = '0;
  logic [31:0]       mem [64];

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[5:0]];

  packed_field_reader #(.IDX_W(IDX_W), .WID_W(WID_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .index(index), .width(width),
    .busy(busy), .done(done), .err(err), .result(result),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_field(input int pos, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < w; b++) begin
      int p = pos + b;
      r[b] = mem[p >> 5][p & 31];
    end
    return r;
  endfunction

  int lat, nreq;
  longint a0, a1;

  // Start a request and observe up to done; optional interfering start at cycle 2.
  task automatic run(input int idx, input int w, input bit poke);
    @(negedge clk);
    index = IDX_W'(idx); width = WID_W'(w); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0; nreq = 0; a0 = -1; a1 = -1;
    for (int k = 1; k < 20; k++) begin
      if (poke && k == 2) begin
        start = 1'b1; index = IDX_W'(idx + 7); width = WID_W'(0);
      end else if (poke && k == 3) begin
        start = 1'b0;
      end
      if (mem_req) begin
        if (nreq == 0) a0 = mem_addr; else a1 = mem_addr;
        nreq++;
      end
      if (done) begin lat = k; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_valid(input int idx, input int w, input string tag);
    int pos = idx * w;
    run(idx, w, 1'b0);
    chk(lat == 4, "R4 latency", lat, 4);
    chk(nreq == 2, "R4 two reads", nreq, 2);
    chk(a0 == (pos >> 5), "R1 first address", a0, pos >> 5);
    chk(a1 == (pos >> 5) + 1, "R1 second address", a1, (pos >> 5) + 1);
    chk(result == ref_field(pos, w), tag, result, ref_field(pos, w));
    chk(err == 1'b0, "R6 err cleared", err, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single", done, 0);
  endtask

  task automatic t_bad(input int w);
    run(3, w, 1'b0);
    chk(lat == 1, "R5 latency", lat, 1);
    chk(nreq == 0, "R5 no reads", nreq, 0);
    chk(err == 1'b1, "R5 err", err, 1);
    chk(result == 0, "R5 result zero", result, 0);
  endtask

  task automatic t_busy_and_hold;
    logic [31:0] exp = ref_field(5 * 7, 7);
    run(5, 7, 1'b1);
    chk(lat == 4, "R7 latency kept", lat, 4);
    chk(a0 == 1 && a1 == 2, "R7 addresses kept", a0, 1);
    chk(err == 1'b0, "R7 no err from ignored start", err, 0);
    chk(result == exp, "R7 result kept", result, exp);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk(result == exp && done == 1'b0, "R6 hold", result, exp);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5C3_1E77 ^ (32'(i) * 32'h9E37_79B1);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_req && result == 0, "R8 reset", result, 0);
    rst_n = 1'b1;
    t_valid(10, 3, "R3 w3 straddle");
    t_valid(7, 5, "R2 w5");
    t_valid(9, 7, "R3 w7 straddle");
    t_valid(3, 17, "R3 w17 straddle");
    t_valid(60, 31, "R3 w31 straddle");
    t_valid(45, 1, "R2 w1");
    t_valid(4, 8, "R2 w8 aligned inside one word");
    t_valid(0, 13, "R2 index zero");
    t_bad(0);
    t_bad(32);
    t_valid(2, 9, "R6 valid after error");
    t_bad(63);
    t_busy_and_hold;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule